// File: doc/BRIEF.md
# Seconds Counter Clock with Match Alarms

This block keeps elapsed time as a pair of 32-bit counters advanced by an external one-second tick: an up-counter of seconds and a down-counter that, when software loads it correctly, always holds the bitwise complement of the up-counter. Two 32-bit compare registers watch the up-counter. A hit latches a status bit, and that bit can raise the interrupt, drive the wake-switch output, or both. A control register also carries a force-high for the wake switch, a soft reset and a counting freeze. A 32-bit key register keeps whatever software writes into it, so firmware can store a marker value such as 0xB5C13F27 to record that the clock has already been configured.

Software reaches every register through a simple word-addressed write strobe and a combinational read port. To set the time, software freezes counting, loads both counters and then releases the freeze. To disarm an alarm, software writes all ones into its compare register.

Top module: `sec_rtc`

## Requirements
- R1: After the asynchronous reset, the counters, control, status and key all read zero, both compare registers read 0xFFFFFFFF, and both the interrupt and wake-switch outputs are low.
- R2: The byte offsets are 0x00 up-counter, 0x04 down-counter, 0x08 compare 0, 0x0C compare 1, 0x10 control, 0x14 status and 0x18 key. Compare and control registers read back what was written. Control bit 5 and bits 31:8 always read zero. Any other offset reads zero.
- R3: On a clock edge where tick is high, control bit 6 (freeze) is clear and control bit 4 (soft reset) is clear, the up-counter increments by one and the down-counter decrements by one, both wrapping modulo 2^32.
- R4: A write to either counter takes effect only while control bit 6 is set. Otherwise the write is ignored.
- R5: Status bit i (i = 0, 1) sets on the edge after the up-counter equals compare register i. It then stays set until status is written with bit i = 1. Writing a 0 to bit i leaves it unchanged. If the equality still holds, setting takes priority over clearing.
- R6: A compare register holding 0xFFFFFFFF never sets its status bit, even when the up-counter equals 0xFFFFFFFF.
- R7: The interrupt output equals (status0 AND control bit 0) OR (status1 AND control bit 1).
- R8: The wake-switch output equals control bit 7 OR (status0 AND control bit 2) OR (status1 AND control bit 3). Status bit 2 sets on the edge after that routed term is true, and it is cleared by writing 1 to it.
- R9: While control bit 4 is set, both counters and all status bits are forced to zero and ticks and counter writes have no effect. Control, compare and key registers keep their values.
- R10: The key register stores any 32-bit value written to it, reads it back, and is not affected by soft reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse, once per second, synchronous to clk |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 5 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Combinational read data for bus_addr_i |
| irq_o | output | 1 | Alarm interrupt |
| pwr_sw_o | output | 1 | Wake-switch output |

## Verification
The compare logic is driven in two ways. Directed sequences place a compare value just ahead of the count, and random compare writes land within a few seconds of the current count, so hits, repeated equality and late clears all occur. These sequences separate a level-sensitive latch from an edge-only one, and they show whether set or clear wins when both happen together. Counter loads are issued with the freeze bit both set and clear, and a wrap from 0xFFFFFFFF to zero is driven on purpose. Together these show whether the loads are gated by the freeze bit and whether the all-ones compare value stays inert at that exact count. Soft-reset pulses are mixed into the random control writes, which shows which state they clear and which state survives them.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 5;
  localparam int N_CMP   = 2;

  // Byte offsets of the register file
  localparam int OFF_UP  = 'h00;
  localparam int OFF_DN  = 'h04;
  localparam int OFF_CMP = 'h08;  // compare i at OFF_CMP + 4*i
  localparam int OFF_CTL = 'h10;
  localparam int OFF_STS = 'h14;
  localparam int OFF_KEY = 'h18;

  // Control bit positions
  localparam int CB_IE   = 0;     // interrupt enables, N_CMP bits
  localparam int CB_RT   = 2;     // wake-switch routing, N_CMP bits
  localparam int CB_SRST = 4;
  localparam int CB_HALT = 6;
  localparam int CB_FORCE = 7;
  localparam int CTL_W   = 8;
  localparam logic [CTL_W-1:0] CTL_MASK = 8'hDF;
endpackage

// File: rtl/sec_rtc_cnt.sv
module sec_rtc_cnt #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          srst_i,
  input  logic          step_i,
  input  logic          ld_up_i,
  input  logic          ld_dn_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] up_o,
  output logic [DW-1:0] dn_o
);
  logic [DW-1:0] up_q, up_d, dn_q, dn_d;

  always_comb begin
    up_d = up_q;
    dn_d = dn_q;
    if (srst_i) begin
      up_d = '0;
      dn_d = '0;
    end else begin
      if (ld_up_i)      up_d = wdata_i;
      else if (step_i)  up_d = up_q + 1'b1;
      if (ld_dn_i)      dn_d = wdata_i;
      else if (step_i)  dn_d = dn_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= '0;
      dn_q <= '0;
    end else begin
      up_q <= up_d;
      dn_q <= dn_d;
    end
  end

  assign up_o = up_q;
  assign dn_o = dn_q;

  AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    srst_i |=> (up_q == '0 && dn_q == '0)); // R9
  AST_STEP_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !srst_i && !ld_up_i && !ld_dn_i) |=>
      (up_q == DW'($past(up_q) + 1'b1) && dn_q == DW'($past(dn_q) - 1'b1))); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !srst_i && !ld_up_i) |=> $stable(up_q)); // R4
endmodule

// File: rtl/sec_rtc_cmp.sv
module sec_rtc_cmp #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          srst_i,
  input  logic [DW-1:0] count_i,
  input  logic [DW-1:0] match_i,
  input  logic          clr_i,
  output logic          sts_o
);
  logic hit, sts_q, sts_d;

  assign hit = (count_i == match_i) && (match_i != '1);

  always_comb begin
    sts_d = sts_q;
    if (srst_i)     sts_d = 1'b0;
    else if (hit)   sts_d = 1'b1;
    else if (clr_i) sts_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= 1'b0;
    else        sts_q <= sts_d;
  end

  assign sts_o = sts_q;

  AST_ALLONES_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (match_i == '1 && !sts_q) |=> !sts_q); // R6
  AST_ROSE_ON_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q) |-> $past(count_i == match_i)); // R5
  AST_SRST_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    srst_i |=> !sts_q); // R9
endmodule

// File: rtl/sec_rtc_regs.sv
module sec_rtc_regs
  import sec_rtc_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int NC = N_CMP
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [DW-1:0]         wdata_i,
  input  logic [DW-1:0]         up_i,
  input  logic [DW-1:0]         dn_i,
  input  logic [NC-1:0]         sts_i,
  output logic [DW-1:0]         rdata_o,
  output logic [CTL_W-1:0]      ctrl_o,
  output logic [NC-1:0][DW-1:0] match_o,
  output logic                  ld_up_o,
  output logic                  ld_dn_o,
  output logic [NC-1:0]         clr_o,
  output logic                  psw_sts_o
);
  logic [CTL_W-1:0] ctrl_q, ctrl_d;
  logic [DW-1:0]    key_q, key_d;
  logic             psw_q, psw_d;
  logic             wr_ctl, wr_sts, wr_key, halted, srst, routed;

  assign wr_ctl  = wr_i && (addr_i == AW'(OFF_CTL));
  assign wr_sts  = wr_i && (addr_i == AW'(OFF_STS));
  assign wr_key  = wr_i && (addr_i == AW'(OFF_KEY));
  assign halted  = ctrl_q[CB_HALT];
  assign srst    = ctrl_q[CB_SRST];
  assign ld_up_o = wr_i && (addr_i == AW'(OFF_UP)) && halted;
  assign ld_dn_o = wr_i && (addr_i == AW'(OFF_DN)) && halted;
  assign routed  = |(sts_i & ctrl_q[CB_RT +: NC]);

  for (genvar i = 0; i < NC; i++) begin : g_cmp_reg
    logic [DW-1:0] m_q, m_d;
    logic          m_en;
    assign m_en = wr_i && (addr_i == AW'(OFF_CMP + 4*i));
    always_comb m_d = m_en ? wdata_i : m_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) m_q <= '1;
      else        m_q <= m_d;
    end
    assign match_o[i] = m_q;
    assign clr_o[i]   = wr_sts && wdata_i[i];
  end

  always_comb begin
    ctrl_d = wr_ctl ? (wdata_i[CTL_W-1:0] & CTL_MASK) : ctrl_q;
    key_d  = wr_key ? wdata_i : key_q;
    psw_d  = psw_q;
    if (srst)                     psw_d = 1'b0;
    else if (routed)              psw_d = 1'b1;
    else if (wr_sts && wdata_i[NC]) psw_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      key_q  <= '0;
      psw_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      key_q  <= key_d;
      psw_q  <= psw_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      AW'(OFF_UP):  rdata_o = up_i;
      AW'(OFF_DN):  rdata_o = dn_i;
      AW'(OFF_CTL): rdata_o = DW'(ctrl_q);
      AW'(OFF_STS): rdata_o = DW'({psw_q, sts_i});
      AW'(OFF_KEY): rdata_o = key_q;
      default:      rdata_o = '0;
    endcase
    for (int i = 0; i < NC; i++)
      if (addr_i == AW'(OFF_CMP + 4*i)) rdata_o = match_o[i];
  end

  assign ctrl_o    = ctrl_q;
  assign psw_sts_o = psw_q;

  AST_LOAD_ONLY_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_up_o || ld_dn_o) |-> ctrl_q[CB_HALT]); // R4
  AST_PSW_SRST: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[CB_SRST] |=> !psw_q); // R9
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[5]); // R2
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
  import sec_rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic              pwr_sw_o
);
  logic [DATA_W-1:0]            up_cnt, dn_cnt;
  logic [CTL_W-1:0]             ctrl;
  logic [N_CMP-1:0][DATA_W-1:0] match_val;
  logic [N_CMP-1:0]             sts, clr;
  logic                         ld_up, ld_dn, psw_sts, step;

  assign step = tick_i && !ctrl[CB_HALT];

  sec_rtc_regs #(.DW(DATA_W), .AW(ADDR_W), .NC(N_CMP)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .up_i(up_cnt), .dn_i(dn_cnt), .sts_i(sts),
    .rdata_o(bus_rdata_o), .ctrl_o(ctrl), .match_o(match_val),
    .ld_up_o(ld_up), .ld_dn_o(ld_dn), .clr_o(clr), .psw_sts_o(psw_sts)
  );

  sec_rtc_cnt #(.DW(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .srst_i(ctrl[CB_SRST]), .step_i(step),
    .ld_up_i(ld_up), .ld_dn_i(ld_dn), .wdata_i(bus_wdata_i),
    .up_o(up_cnt), .dn_o(dn_cnt)
  );

  for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
    sec_rtc_cmp #(.DW(DATA_W)) u_cmp (
      .clk(clk), .rst_n(rst_n), .srst_i(ctrl[CB_SRST]), .count_i(up_cnt),
      .match_i(match_val[i]), .clr_i(clr[i]), .sts_o(sts[i])
    );
  end

  assign irq_o    = |(sts & ctrl[CB_IE +: N_CMP]);
  assign pwr_sw_o = ctrl[CB_FORCE] || (|(sts & ctrl[CB_RT +: N_CMP]));

  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (sts != '0)); // R7
  AST_PSW_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_sw_o |-> (ctrl[CB_FORCE] || sts != '0)); // R8
  AST_PSW_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(psw_sts) |-> $past(sts != '0)); // R8
endmodule

// File: tb/sec_rtc_bench.sv
module sec_rtc_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick;
  logic        wr;
  logic [4:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq, psw;

  always #10 clk = ~clk;

  sec_rtc u_sec_rtc (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq), .pwr_sw_o(psw)
  );

  int n_vec = 0;
  int n_bad = 0;

  // Reference state
  logic [31:0] m_up, m_dn, m_key;
  logic [31:0] m_cmp [2];
  logic [7:0]  m_ctl;
  logic [2:0]  m_sts;

  function automatic logic [31:0] exp_rd(input logic [4:0] a);
    case (a)
      5'h00: return m_up;
      5'h04: return m_dn;
      5'h08: return m_cmp[0];
      5'h0C: return m_cmp[1];
      5'h10: return {24'h0, m_ctl};
      5'h14: return {29'h0, m_sts};
      5'h18: return m_key;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic exp_irq();
    return (m_sts[0] & m_ctl[0]) | (m_sts[1] & m_ctl[1]);
  endfunction

  function automatic logic exp_psw();
    return m_ctl[7] | (m_sts[0] & m_ctl[2]) | (m_sts[1] & m_ctl[3]);
  endfunction

  function automatic string tag_of(input logic [4:0] a);
    case (a)
      5'h00, 5'h04: return "R3";
      5'h14:        return "R5";
      5'h18:        return "R10";
      default:      return "R2";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // One clock cycle: drive, compare current state, advance reference.
  task automatic cyc(input logic w, input logic [4:0] a, input logic [31:0] d,
                     input logic t, input string tag = "");
    logic [31:0] n_up, n_dn, n_key;
    logic [31:0] n_cmp [2];
    logic [7:0]  n_ctl;
    logic [2:0]  n_sts;
    logic        srst, halt;
    @(negedge clk);
    wr = w; addr = a; wdata = d; tick = t;
    #1;
    chk((tag == "") ? tag_of(a) : tag, rdata, exp_rd(a));
    chk("R7", {31'h0, irq}, {31'h0, exp_irq()});
    chk("R8", {31'h0, psw}, {31'h0, exp_psw()});
    srst = m_ctl[4]; halt = m_ctl[6];
    n_up = m_up; n_dn = m_dn; n_ctl = m_ctl; n_key = m_key;
    n_cmp[0] = m_cmp[0]; n_cmp[1] = m_cmp[1]; n_sts = m_sts;
    if (srst) begin
      n_up = 0; n_dn = 0; n_sts = 0;
    end else begin
      if (w && a == 5'h00 && halt) n_up = d;
      else if (t && !halt)         n_up = m_up + 1;
      if (w && a == 5'h04 && halt) n_dn = d;
      else if (t && !halt)         n_dn = m_dn - 1;
      for (int i = 0; i < 2; i++) begin
        if (m_up == m_cmp[i] && m_cmp[i] != 32'hFFFF_FFFF) n_sts[i] = 1'b1;
        else if (w && a == 5'h14 && d[i])                 n_sts[i] = 1'b0;
      end
      if ((m_sts[0] & m_ctl[2]) | (m_sts[1] & m_ctl[3])) n_sts[2] = 1'b1;
      else if (w && a == 5'h14 && d[2])                  n_sts[2] = 1'b0;
    end
    if (w && a == 5'h08) n_cmp[0] = d;
    if (w && a == 5'h0C) n_cmp[1] = d;
    if (w && a == 5'h10) n_ctl = d[7:0] & 8'hDF;
    if (w && a == 5'h18) n_key = d;
    @(posedge clk);
    m_up = n_up; m_dn = n_dn; m_ctl = n_ctl; m_key = n_key; m_sts = n_sts;
    m_cmp[0] = n_cmp[0]; m_cmp[1] = n_cmp[1];
    #1;
    wr = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input string tag);
    cyc(1'b0, a, 32'h0, 1'b0, tag);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; tick = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    m_up = 0; m_dn = 0; m_key = 0; m_ctl = 0; m_sts = 0;
    m_cmp[0] = 32'hFFFF_FFFF; m_cmp[1] = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state on every offset, outputs low
    for (int a = 0; a < 32; a += 4) rd(5'(a), "R1");
    chk("R1", {30'h0, irq, psw}, 32'h0);
    rd(5'h01, "R2");  // unaligned offset reads zero

    // R3 wrap and R6 all-ones compare at count 0xFFFFFFFF
    cyc(1, 5'h10, 32'h40, 0);
    cyc(1, 5'h00, 32'hFFFF_FFFE, 0);
    cyc(1, 5'h04, 32'h0000_0001, 0);
    cyc(1, 5'h10, 32'hFFFF_FF00, 0);     // upper bits must read zero (R2)
    rd(5'h10, "R2");
    cyc(0, 5'h00, 0, 1);
    rd(5'h00, "R3");
    cyc(0, 5'h00, 0, 1);                 // wraps to 0
    rd(5'h00, "R3");
    rd(5'h04, "R3");
    rd(5'h14, "R6");

    // R4: counter write while running is ignored
    cyc(1, 5'h00, 32'h1234, 0);
    rd(5'h00, "R4");
    cyc(1, 5'h10, 32'h40, 0);
    cyc(1, 5'h04, 32'hFFFF_FFF0, 0);
    cyc(1, 5'h00, 32'h0000_000F, 0);
    rd(5'h00, "R4");

    // R5, R7, R8: compare 1 routed to both outputs
    cyc(1, 5'h0C, 32'h11, 0);
    cyc(1, 5'h10, 32'h0A, 0);
    cyc(0, 5'h14, 0, 1);
    cyc(0, 5'h14, 0, 1);
    rd(5'h14, "R5");
    chk("R7", {31'h0, irq}, 32'h1);
    cyc(0, 5'h14, 0, 1);                 // move off the compare value
    cyc(1, 5'h14, 32'h0, 0);             // writing zero keeps status
    rd(5'h14, "R5");
    cyc(1, 5'h14, 32'h7, 0);
    rd(5'h14, "R5");
    chk("R8", {31'h0, psw}, 32'h0);
    cyc(1, 5'h10, 32'h80, 0);
    chk("R8", {31'h0, psw}, 32'h1);

    // R10 and R9: key survives soft reset, counters forced to zero
    cyc(1, 5'h18, 32'hB5C1_3F27, 0);
    cyc(1, 5'h10, 32'h10, 0);
    cyc(0, 5'h00, 0, 1);
    rd(5'h00, "R9");
    rd(5'h18, "R10");
    cyc(1, 5'h10, 32'h0, 0);

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      int op;
      logic t;
      op = $urandom % 10;
      t = ($urandom % 3) == 0;
      case (op)
        6: cyc(1, ($urandom % 2) ? 5'h08 : 5'h0C, m_up + ($urandom % 6), t);
        7: cyc(1, 5'h10, ($urandom & 32'hFFFF_FFEF) | ((($urandom % 10) == 0) ? 32'h10 : 32'h0), t);
        8: cyc(1, 5'h14, $urandom % 8, t);
        9: cyc(1, 5'(4 * ($urandom % 8)), $urandom, t);
        default: cyc(0, 5'(4 * ($urandom % 8)), 0, t);
      endcase
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule